// File: doc/BRIEF.md
# Idle-Synchronized Stream Descrambler

This block removes the scrambling from a 100 Mbps block-coded serial line. It sits after clock recovery and line decoding and before code-group alignment. It takes one recovered bit per accepted transfer and a signal-detect level. It produces the descrambled bit on an output stream, together with a `locked` flag.

While the line carries idle code-groups, the plaintext is known to be all ones. The block therefore loads its 11-bit key generator (x^11 + x^9 + 1) from the inverted received bits. It declares lock once the generator has predicted a long enough run of incoming bits without a miss. From then on the generator runs freely and each bit is XORed with its output.

A window counter watches the descrambled stream for idle code-groups. If none is seen within the window, lock is dropped and key acquisition starts again. The window is sized so that the longest legal frame fits inside it.

The streams follow valid/ready rules. The output is valid exactly when the input is. The input is ready exactly when the output is. A bit counts as transferred only in a cycle where both valid and ready are high. No internal state moves in any other cycle, so the downstream side may stall for any length of time without losing key alignment.

Top module: `idle_sync_descrambler`

## Requirements
- R1: After reset `locked` is 0.
- R2: While unlocked with `sig_detect` high, each transferred bit is shifted into the key generator inverted. `locked` rises after LOCK_RUN (default 60) transferred bits in a row whose descrambled value `out_bit` is 1. For a scrambled idle stream this happens no sooner than LOCK_RUN bits and no later than LOCK_RUN+11 bits.
- R3: A scrambled stream whose plaintext alternates 1,0,1,0 never produces lock.
- R4: While locked, `out_bit` equals `in_bit` XOR the free-running key. The key is bit = k[n-9] XOR k[n-11]. The descrambled output therefore reproduces the transmitter's plaintext.
- R5: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. The block's state (key, counters, `locked`) changes only on a transfer, or on loss of signal detect.
- R6: While locked, five consecutive descrambled ones (an idle code-group) restart the idle window.
- R7: While locked, after WINDOW (default 32000) transferred bits with no idle code-group, `locked` falls at the clock edge of the WINDOW-th bit. After WINDOW-1 such bits it is still 1.
- R8: A maximum-length frame of 1514 bytes (12112 bits of non-idle data) followed by idle keeps lock.
- R9: `sig_detect` low clears `locked` at the next clock edge and returns the block to acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_detect | input | 1 | Line signal present |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Block accepts input bit |
| in_bit | input | 1 | Received scrambled bit |
| out_valid | output | 1 | Descrambled bit valid |
| out_ready | input | 1 | Downstream accepts bit |
| out_bit | output | 1 | Descrambled bit |
| locked | output | 1 | Key acquired and held |

## Verification
The hardest state to reach is the exact edge of the idle window. It needs a locked block fed tens of thousands of non-idle bits. The count must also start from a known point. The bench keeps its own scrambler in step with the block and sends a run of five ones just before each long test, so the window count is known to be zero. It then sends exactly WINDOW-1 scrambled zeros, checks that lock is held, and sends one more zero to see lock fall on that bit. A second long run places an idle code-group near the window's end to show the restart.

// File: rtl/descr_pkg.sv
package descr_pkg;
  localparam int KEY_W = 11;
  localparam int TAP_A = 8;   // key delayed by 9 bits
  localparam int TAP_B = 10;  // key delayed by 11 bits
  typedef logic [KEY_W-1:0] key_t;
endpackage

// File: rtl/descr_key_gen.sv
module descr_key_gen
  import descr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  logic acquire,
  input  logic rx_bit,
  output logic key_bit
);
  key_t key_q;

  assign key_bit = key_q[TAP_A] ^ key_q[TAP_B];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q <= '0;
    end else if (advance) begin
      key_q <= {key_q[KEY_W-2:0], acquire ? ~rx_bit : key_bit};
    end
  end
endmodule

// File: rtl/descr_lock_ctrl.sv
module descr_lock_ctrl #(
  parameter int LOCK_RUN = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  logic sig_detect,
  input  logic hit,
  input  logic timeout,
  output logic locked
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !sig_detect) begin
      locked <= 1'b0;
      run_q  <= '0;
    end else if (advance) begin
      if (locked) begin
        if (timeout) begin
          locked <= 1'b0;
          run_q  <= '0;
        end
      end else if (hit) begin
        if (run_q == RUN_W'(LOCK_RUN - 1)) begin
          locked <= 1'b1;
          run_q  <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/descr_idle_watch.sv
module descr_idle_watch #(
  parameter int WINDOW   = 32000,
  parameter int IDLE_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  logic active,
  input  logic plain_bit,
  output logic timeout,
  output logic [$clog2(WINDOW)-1:0] wd_cnt
);
  localparam int WD_W  = $clog2(WINDOW);
  localparam int ONE_W = $clog2(IDLE_LEN);
  logic [ONE_W-1:0] ones_q;
  logic idle_now;

  assign idle_now = plain_bit && (ones_q == ONE_W'(IDLE_LEN - 1));
  assign timeout  = advance && active && !idle_now && (wd_cnt == WD_W'(WINDOW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      ones_q <= '0;
      wd_cnt <= '0;
    end else if (advance) begin
      if (!plain_bit)    ones_q <= '0;
      else if (!idle_now) ones_q <= ones_q + 1'b1;
      wd_cnt <= (idle_now || timeout) ? '0 : wd_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/idle_sync_descrambler.sv
module idle_sync_descrambler #(
  parameter int LOCK_RUN = 60,
  parameter int WINDOW   = 32000,
  parameter int IDLE_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_detect,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic locked
);
  localparam int WD_W = $clog2(WINDOW);

  logic xfer, key_bit, timeout;
  logic [WD_W-1:0] wd_cnt;

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign xfer      = in_valid && out_ready;
  assign out_bit   = in_bit ^ key_bit;

  descr_key_gen u_key (
    .clk(clk), .rst_n(rst_n), .advance(xfer), .acquire(!locked),
    .rx_bit(in_bit), .key_bit(key_bit)
  );

  descr_lock_ctrl #(.LOCK_RUN(LOCK_RUN)) u_lock (
    .clk(clk), .rst_n(rst_n), .advance(xfer), .sig_detect(sig_detect),
    .hit(out_bit), .timeout(timeout), .locked(locked)
  );

  descr_idle_watch #(.WINDOW(WINDOW), .IDLE_LEN(IDLE_LEN)) u_idle (
    .clk(clk), .rst_n(rst_n), .advance(xfer), .active(locked),
    .plain_bit(out_bit), .timeout(timeout), .wd_cnt(wd_cnt)
  );
endmodule

// File: rtl/idle_sync_descrambler_chk.sv
module idle_sync_descrambler_chk #(
  parameter int WINDOW = 32000
) (
  input logic clk,
  input logic rst_n,
  input logic sig_detect,
  input logic in_valid,
  input logic out_ready,
  input logic out_bit,
  input logic locked,
  input logic [$clog2(WINDOW)-1:0] wd_cnt
);
  AST_SD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_detect |=> !locked); // R9
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_detect && !(in_valid && out_ready)) |=> $stable(locked)); // R5
  AST_LOCK_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(in_valid && out_ready && sig_detect)); // R2
  AST_LOCK_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(out_bit)); // R2
  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(!sig_detect || (in_valid && out_ready))); // R7
  AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wd_cnt < ($clog2(WINDOW))'(WINDOW)); // R7
endmodule

bind idle_sync_descrambler idle_sync_descrambler_chk #(.WINDOW(WINDOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sig_detect(sig_detect), .in_valid(in_valid),
  .out_ready(out_ready), .out_bit(out_bit), .locked(locked), .wd_cnt(wd_cnt)
);

// File: tb/tb_idle_sync_descrambler.sv
module tb_idle_sync_descrambler;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK_RUN = 60;
  localparam int WINDOW   = 32000;

  logic clk = 0, rst_n = 0, sig_detect = 0;
  logic in_valid = 0, in_bit = 0, out_ready = 1;
  logic in_ready, out_valid, out_bit, locked;
  logic [10:0] tkey = 11'h5A3;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_sync_descrambler #(.LOCK_RUN(LOCK_RUN), .WINDOW(WINDOW)) dut (
    .clk(clk), .rst_n(rst_n), .sig_detect(sig_detect), .in_valid(in_valid),
    .in_ready(in_ready), .in_bit(in_bit), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit), .locked(locked)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // One transfer of plaintext p; starts and ends at a negedge
  task automatic send(input logic p, input bit chk);
    logic k;
    k = tkey[8] ^ tkey[10];
    in_valid = 1; in_bit = p ^ k;
    #1;
    if (chk) check("R4 descrambled bit", out_bit, p);
    @(posedge clk);
    tkey = {tkey[9:0], k};
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic send_run(input logic p, input int n);
    for (int i = 0; i < n; i++) send(p, 1'b0);
  endtask

  task automatic t_reset;
    check("R1 locked after reset", locked, 1'b0);
    check("R5 out_valid idle", out_valid, 1'b0);
  endtask

  task automatic t_acquire;
    sig_detect = 1;
    send_run(1'b1, LOCK_RUN - 1);
    check("R2 no early lock", locked, 1'b0);
    send_run(1'b1, 12);
    check("R2 locked on idle", locked, 1'b1);
  endtask

  task automatic t_data;
    for (int i = 0; i < 200; i++) send(logic'(((i * 7) % 3) == 0), 1'b1);
    send_run(1'b1, 5);
    check("R4 still locked", locked, 1'b1);
  endtask

  task automatic t_stall;
    out_ready = 0; in_valid = 1;
    for (int i = 0; i < 6; i++) begin
      in_bit = logic'(i % 2);
      #1;
      check("R5 in_ready low", in_ready, 1'b0);
      @(negedge clk);
    end
    in_valid = 0; out_ready = 1;
    #1;
    check("R5 out_valid follows", out_valid, 1'b0);
    @(negedge clk);
    for (int i = 0; i < 30; i++) send(logic'(i % 3 == 1), 1'b1);
    send_run(1'b1, 5);
  endtask

  task automatic t_frame;
    send_run(1'b0, 12112);
    send_run(1'b1, 5);
    check("R8 frame keeps lock", locked, 1'b1);
  endtask

  task automatic t_idle_restart;
    send_run(1'b0, WINDOW - 10);
    send_run(1'b1, 5);
    send_run(1'b0, WINDOW - 10);
    check("R6 idle restarts window", locked, 1'b1);
    send_run(1'b1, 5);
  endtask

  task automatic t_watchdog;
    send_run(1'b0, WINDOW - 1);
    check("R7 held at WINDOW-1", locked, 1'b1);
    send(1'b0, 1'b0);
    check("R7 dropped at WINDOW", locked, 1'b0);
  endtask

  task automatic t_relock;
    send_run(1'b1, LOCK_RUN + 11);
    check("R2 relock", locked, 1'b1);
  endtask

  task automatic t_sig_loss;
    sig_detect = 0;
    @(negedge clk);
    check("R9 signal loss unlocks", locked, 1'b0);
    sig_detect = 1;
    send_run(1'b1, 20);
    check("R9 reacquiring", locked, 1'b0);
  endtask

  task automatic t_no_lock_alt;
    for (int i = 0; i < 400; i++) send(logic'(i % 2 == 0), 1'b0);
    check("R3 alternating no lock", locked, 1'b0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_acquire();
    t_data();
    t_stall();
    t_frame();
    t_idle_restart();
    t_watchdog();
    t_relock();
    t_sig_loss();
    t_no_lock_alt();
    t_relock();
    finish_run();
  end
endmodule